// File: doc/BRIEF.md
# Counter-Paced Serial Shift Slice with Double Buffer

This block is one serial shift lane. A 32-bit working register moves right by one place whenever a reloadable down counter runs out. On each such move the lane samples a serial input bit into the top bit, and it drives the serial output from the bottom bit at all times. The counter therefore sets the bit rate as a number of system clocks, independent of the system clock itself.

A second counter, the position counter, counts these shift events. When it runs out, the working register and a shadow register trade places in one cycle. While the lane shifts one word, software can fill or drain the other. A small write/read register port gives access to the working register, the shadow register, the reload value, the live count and the position counter, plus set and clear locations for the run enable. Two single-cycle event pulses mark each shift and each swap.

The serial pins have no valid/ready handshake. The counter alone fixes when a bit is taken and when one is presented, so the lane gives no back-pressure and accepts none. A consumer that cannot keep up must lengthen the reload value.

Top module: `shift_slice`

## Requirements
- R1: After reset every register reads as zero, the lane is stopped, both event pulses are low and the serial output is 0.
- R2: Writing a value with bit 0 set to address 5 starts the lane, and writing a value with bit 0 set to address 6 stops it. A write with bit 0 clear changes nothing. Reading address 5 returns the run state in bit 0.
- R3: While the lane runs, the count (address 3) falls by one per clock. In the clock after it reads zero it holds the reload value (address 2). Shifts are therefore spaced reload+1 clocks apart.
- R4: On each count expiry the working register (address 0) becomes {serial input, old[31:1]}, with the input sampled at that clock edge. The serial output always equals bit 0 of the working register.
- R5: The position register (address 4) holds the current position in bits 7:0 and the position reload in bits 15:8. Each expiry decrements the current field. An expiry that finds the current field at zero instead swaps the two data registers and reloads the current field from bits 15:8, so a swap occurs every reload+1 shifts.
- R6: When a shift and a swap fall on the same clock, the working register takes the old shadow value and the shadow register (address 1) takes the shifted working value.
- R7: The shift pulse is high for exactly the one clock that follows each expiry edge. The swap pulse is high in the same clock as a shift pulse whenever that expiry swapped, and at no other time.
- R8: A bus write to a register wins over any counter or shift update of that same register in the same clock.
- R9: While the lane is stopped, the count, the position and both data registers hold, no pulses occur, and the serial input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Write address (0 data, 1 shadow, 2 reload, 3 count, 4 position, 5 run set, 6 run clear) |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 3 | Read address, same map as writes |
| bus_rdata | output | 32 | Combinational read data, zero-extended |
| ser_in | input | 1 | Serial input bit |
| ser_out | output | 1 | Serial output bit |
| shift_evt | output | 1 | One-clock pulse after each shift |
| swap_evt | output | 1 | One-clock pulse after each swap |

## Verification
The main function is swept over count reload values 0 to 3 crossed with position reload values 0 to 2. Each case runs for a different length and ends with a bench-computed comparison of the data, shadow, count, position and pulse totals. The serial input flips after every shift, so bit order and sample timing show up in the final words. Reload 0 gives back-to-back shifts, and position reload 0 gives a swap on every shift, which exposes the shift-then-swap ordering. Writes that land on an expiring and swapping clock separate bus priority from counter priority, and a stopped interval with a toggling input confirms that nothing moves.

// File: rtl/shift_slice_pkg.sv
package shift_slice_pkg;
  typedef enum logic [2:0] {
    A_DATA   = 3'd0,
    A_SHADOW = 3'd1,
    A_PRESET = 3'd2,
    A_COUNT  = 3'd3,
    A_POS    = 3'd4,
    A_RUNSET = 3'd5,
    A_RUNCLR = 3'd6
  } slice_addr_e;
endpackage

// File: rtl/shift_slice_timer.sv
// Reloadable down counter; flags expiry combinationally.
module shift_slice_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (ld)     cnt <= ld_val;
    else if (expire) cnt <= reload;
    else if (run)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/shift_slice_posctr.sv
// Counts shift events; flags the swap when the current field is zero.
module shift_slice_posctr #(
  parameter int POS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               ld,
  input  logic [2*POS_W-1:0] ld_val,
  output logic [POS_W-1:0]   cur,
  output logic [POS_W-1:0]   rld,
  output logic               wrap
);
  assign wrap = step && (cur == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
      rld <= '0;
    end else if (ld) begin
      {rld, cur} <= ld_val;
    end else if (wrap) begin
      cur <= rld;
    end else if (step) begin
      cur <= cur - 1'b1;
    end
  end
endmodule

// File: rtl/shift_slice_datapath.sv
// Working and shadow registers with shift-then-swap ordering.
module shift_slice_datapath #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              swap,
  input  logic              sin,
  input  logic              wr_work,
  input  logic              wr_shadow,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] work,
  output logic [DATA_W-1:0] shadow
);
  logic [DATA_W-1:0] shifted;
  assign shifted = {sin, work[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         work <= '0;
    else if (wr_work)   work <= wdata;
    else if (swap)      work <= shadow;
    else if (shift)     work <= shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow <= '0;
    else if (wr_shadow) shadow <= wdata;
    else if (swap)      shadow <= shifted;
  end
endmodule

// File: rtl/shift_slice.sv
module shift_slice
  import shift_slice_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int POS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [2:0]        bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              shift_evt,
  output logic              swap_evt
);
  localparam int CNT_PAD = DATA_W - CNT_W;
  localparam int POS_PAD = DATA_W - 2*POS_W;

  logic              en_q;
  logic [CNT_W-1:0]  preset_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [POS_W-1:0]  pos_cur, pos_rld;
  logic [DATA_W-1:0] data_q, shadow_q;
  logic              expire, wrap;
  logic              wr_data, wr_shadow, wr_preset, wr_count, wr_pos, wr_set, wr_clr;

  assign wr_data   = bus_we && (bus_waddr == A_DATA);
  assign wr_shadow = bus_we && (bus_waddr == A_SHADOW);
  assign wr_preset = bus_we && (bus_waddr == A_PRESET);
  assign wr_count  = bus_we && (bus_waddr == A_COUNT);
  assign wr_pos    = bus_we && (bus_waddr == A_POS);
  assign wr_set    = bus_we && (bus_waddr == A_RUNSET) && bus_wdata[0];
  assign wr_clr    = bus_we && (bus_waddr == A_RUNCLR) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (wr_set) en_q <= 1'b1;
    else if (wr_clr) en_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         preset_q <= '0;
    else if (wr_preset) preset_q <= bus_wdata[CNT_W-1:0];
  end

  shift_slice_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(en_q), .ld(wr_count),
    .ld_val(bus_wdata[CNT_W-1:0]), .reload(preset_q),
    .cnt(cnt_q), .expire(expire)
  );

  shift_slice_posctr #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(expire), .ld(wr_pos),
    .ld_val(bus_wdata[2*POS_W-1:0]),
    .cur(pos_cur), .rld(pos_rld), .wrap(wrap)
  );

  shift_slice_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .shift(expire), .swap(wrap), .sin(ser_in),
    .wr_work(wr_data), .wr_shadow(wr_shadow), .wdata(bus_wdata),
    .work(data_q), .shadow(shadow_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_evt <= 1'b0;
      swap_evt  <= 1'b0;
    end else begin
      shift_evt <= expire;
      swap_evt  <= wrap;
    end
  end

  assign ser_out = data_q[0];

  always_comb begin
    bus_rdata = '0;
    case (bus_raddr)
      A_DATA:   bus_rdata = data_q;
      A_SHADOW: bus_rdata = shadow_q;
      A_PRESET: bus_rdata = {{CNT_PAD{1'b0}}, preset_q};
      A_COUNT:  bus_rdata = {{CNT_PAD{1'b0}}, cnt_q};
      A_POS:    bus_rdata = {{POS_PAD{1'b0}}, pos_rld, pos_cur};
      A_RUNSET: bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/shift_slice_chk.sv
module shift_slice_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic              ser_in,
  input logic              en_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  preset_q,
  input logic [DATA_W-1:0] data_q,
  input logic [DATA_W-1:0] shadow_q,
  input logic              shift_evt,
  input logic              swap_evt
);
  // R3
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q == '0 && !bus_we) |=> cnt_q == $past(preset_q));

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q != '0 && !bus_we) |=> cnt_q == $past(cnt_q) - {{(CNT_W-1){1'b0}}, 1'b1});

  // R4
  shift_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q == '0 && !bus_we) |=> (swap_evt ||
      data_q == {$past(ser_in), $past(data_q[DATA_W-1:1])}));

  // R6
  swap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q == '0 && !bus_we) |=> (!swap_evt ||
      (shadow_q == {$past(ser_in), $past(data_q[DATA_W-1:1])} && data_q == $past(shadow_q))));

  // R7
  swap_with_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> shift_evt);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !bus_we) |=> ($stable(cnt_q) && $stable(data_q) && !shift_evt));
endmodule

bind shift_slice shift_slice_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .ser_in(ser_in), .en_q(en_q),
  .cnt_q(cnt_q), .preset_q(preset_q), .data_q(data_q), .shadow_q(shadow_q),
  .shift_evt(shift_evt), .swap_evt(swap_evt)
);

// File: tb/shift_slice_bench.sv
`timescale 1ns/1ps
module shift_slice_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic        ser_in = 1'b0;
  logic        ser_out, shift_evt, swap_evt;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  shift_slice u_shift_slice (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .ser_in(ser_in), .ser_out(ser_out), .shift_evt(shift_evt), .swap_evt(swap_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_raddr = a; #0.5;
    d = bus_rdata;
  endtask

  task automatic run_case(input int p, input int r, input int k);
    logic [31:0] md, ms, sh, tmp, v;
    int mc, mp, nsh, nsw, osh, osw;
    logic sv;
    md = 32'hA5C3_0F69 ^ (p * 37 + r); ms = 32'h1234_5678 + p * 256 + r;
    ser_in = 1'b1; sv = 1'b1;
    wr(3'd0, md); wr(3'd1, ms); wr(3'd2, p); wr(3'd3, p); wr(3'd4, (r << 8) | r);
    wr(3'd5, 32'd1);
    mc = p; mp = r; nsh = 0; nsw = 0; osh = 0; osw = 0;
    for (int e = 0; e < k + 1; e++) begin
      if (mc == 0) begin
        sh = {sv, md[31:1]}; nsh++;
        if (mp == 0) begin tmp = ms; ms = sh; md = tmp; mp = r; nsw++; end
        else begin md = sh; mp--; end
        mc = p; sv = ~sv;
      end else mc--;
    end
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1;
      if (shift_evt) begin osh++; ser_in = ~ser_in; end
      if (swap_evt) osw++;
    end
    wr(3'd6, 32'd1);
    if (shift_evt) osh++;
    if (swap_evt) osw++;
    chk("R3/R7 shift pulse total", osh, nsh);
    chk("R5/R7 swap pulse total", osw, nsw);
    rd(3'd0, v); chk("R4/R6 data word", v, md);
    rd(3'd1, v); chk("R6 shadow word", v, ms);
    rd(3'd3, v); chk("R3 count value", v, mc);
    rd(3'd4, v); chk("R5 position value", v, (r << 8) | mp);
    chk("R4 serial out", ser_out, md[0]);
  endtask

  initial begin
    logic [31:0] v, c0, d0;
    int pulses;
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin rd(a[2:0], v); chk("R1 reset register", v, 32'd0); end
    chk("R1 reset pulses", {shift_evt, swap_evt, ser_out}, 32'd0);
    // R2 write with bit 0 clear does not start the lane
    wr(3'd5, 32'd2); rd(3'd5, v); chk("R2 set with bit0 clear", v, 32'd0);
    wr(3'd5, 32'd1); rd(3'd5, v); chk("R2 run set", v, 32'd1);
    wr(3'd6, 32'd0); rd(3'd5, v); chk("R2 clear with bit0 clear", v, 32'd1);
    wr(3'd6, 32'd1); rd(3'd5, v); chk("R2 run clear", v, 32'd0);
    // Sweep of reload and position reload
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 3; r++)
        run_case(p, r, 17 + 3 * p + r);
    // R8 bus write on an expiring, swapping clock
    wr(3'd2, 0); wr(3'd3, 0); wr(3'd4, 0); wr(3'd5, 1);
    wr(3'd0, 32'hDEAD_BEEF);
    rd(3'd0, v); chk("R8 data write priority", v, 32'hDEAD_BEEF);
    wr(3'd3, 32'd5);
    rd(3'd3, v); chk("R8 count write priority", v, 32'd5);
    wr(3'd6, 1);
    // R9 stopped lane ignores input and time
    rd(3'd3, c0); rd(3'd0, d0); pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1; ser_in = ~ser_in;
      if (shift_evt || swap_evt) pulses++;
    end
    rd(3'd3, v); chk("R9 count holds", v, c0);
    rd(3'd0, v); chk("R9 data holds", v, d0);
    chk("R9 no pulses", pulses, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule